// File: doc/BRIEF.md
# Selectable Dot Clock Enable Generator

This block sits in the master clock domain of a video display processor. Each time the pixel pipeline should advance, it raises a single-cycle dot enable. It also keeps the horizontal dot position. All horizontal timing downstream is derived from that dot position and not from master clock cycles.

Two mode inputs set the timing. The source bit picks the dot enable source:

- An internal divider, or
- An external clock that runs at twice the pixel rate. This clock is resynchronised through two flops, and a rising edge is detected on it.

The width bit picks narrow or wide line timing. It sets both the internal divide ratio and the number of dot ticks per line.

A third input, horizontal-sync-off, forces the internal divider while wide timing is selected. A new mode is accepted only at the end of a line. The active mode is reported so the rest of the chip can follow it.

Top module: `dot_tick_gen`

## Requirements
- R1: While the external source is active, every rising edge of `ext_clk_i` produces exactly one `dot_en_o` pulse. With a steady external period of P master cycles, a line therefore lasts dots × P cycles.
- R2: While the internal source is active, `dot_en_o` pulses once every 5 master cycles in narrow timing and once every 4 in wide timing. It is never high on two consecutive cycles.
- R3: `wide_sel_i` = 0 selects narrow line timing and 1 selects wide line timing. This choice applies to both the internal and the external source.
- R4: `dot_cnt_o` advances by one on each dot enable. It runs 0..683 in narrow timing (684 ticks) and 0..839 in wide timing (840 ticks), then returns to 0.
- R5: With the internal source, a narrow line lasts exactly 3420 master cycles and a wide line exactly 3360.
- R6: When `wide_sel_i` = 1 and `hsync_off_i` = 1, the internal divide-by-4 source is used even if `clk_src_sel_i` = 1. In narrow timing, `hsync_off_i` has no effect.
- R7: `ext_clk_i` passes through a two-flop synchronizer. A dot enable from the external source appears in the third cycle after the edge at which the input is first sampled high.
- R8: Mode inputs are sampled only at the edge that ends a line. `wide_act_o` and `ext_act_o` hold the active mode and never change in the middle of a line.
- R9: `eol_o` is high for exactly one cycle. It coincides with the dot enable on which `dot_cnt_o` wraps from its last value to 0.
- R10: After reset, the block runs in narrow timing from the internal source, with the counter at 0 and no enable or end-of-line pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_src_sel_i | input | 1 | 1 = external dot source requested |
| wide_sel_i | input | 1 | 0 = narrow timing, 1 = wide timing |
| hsync_off_i | input | 1 | Horizontal sync disabled; forces internal source in wide timing |
| ext_clk_i | input | 1 | External clock at twice the pixel rate, asynchronous |
| dot_en_o | output | 1 | One-cycle dot enable |
| dot_cnt_o | output | 10 | Horizontal dot position |
| eol_o | output | 1 | End-of-line strobe |
| wide_act_o | output | 1 | Active line is wide timing |
| ext_act_o | output | 1 | Active line uses the external source |

## Verification
The hazard case is a mode request that changes in the very cycle the line wraps. The driver rewrites all three mode inputs on the falling edge inside each end-of-line cycle, so the wrapping edge latches the new mode at once. A few cycles later it flips every input to the opposite value and holds that until the next wrap. The scoreboard then judges each line by four things: its dot count, its master-cycle length, the active-mode flags reported at the wrap, and the counter reading 0 on the following cycle. A mid-line leak or a late latch would shift one of these.

// File: rtl/dot_tick_gen.sv
module dot_tick_gen #(
  parameter int NARROW_DIV  = 5,
  parameter int WIDE_DIV    = 4,
  parameter int NARROW_DOTS = 684,
  parameter int WIDE_DOTS   = 840
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_src_sel_i,
  input  logic       wide_sel_i,
  input  logic       hsync_off_i,
  input  logic       ext_clk_i,
  output logic       dot_en_o,
  output logic [9:0] dot_cnt_o,
  output logic       eol_o,
  output logic       wide_act_o,
  output logic       ext_act_o
);
  localparam int MAX_DIV = (NARROW_DIV > WIDE_DIV) ? NARROW_DIV : WIDE_DIV;
  localparam int DW = $clog2(MAX_DIV + 1);
  localparam logic [DW-1:0] N_LIM = DW'(NARROW_DIV - 1);
  localparam logic [DW-1:0] W_LIM = DW'(WIDE_DIV - 1);
  localparam logic [9:0]    N_LAST = 10'(NARROW_DOTS - 1);
  localparam logic [9:0]    W_LAST = 10'(WIDE_DOTS - 1);

  logic [2:0]    sync_q;
  logic [DW-1:0] div_q;
  logic [9:0]    cnt_q;
  logic          act_wide, act_ext;

  wire ext_rise = sync_q[1] & ~sync_q[2];
  wire int_tick = (div_q == (act_wide ? W_LIM : N_LIM));
  wire [9:0] last_dot = act_wide ? W_LAST : N_LAST;
  wire wrap = (cnt_q == last_dot);

  assign dot_en_o   = act_ext ? ext_rise : int_tick;
  assign eol_o      = dot_en_o & wrap;
  assign dot_cnt_o  = cnt_q;
  assign wide_act_o = act_wide;
  assign ext_act_o  = act_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= '0;
      div_q    <= '0;
      cnt_q    <= '0;
      act_wide <= 1'b0;
      act_ext  <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], ext_clk_i};
      if (act_ext || int_tick) div_q <= '0;
      else                     div_q <= div_q + 1'b1;
      if (dot_en_o) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (eol_o) begin
        act_wide <= wide_sel_i;
        act_ext  <= clk_src_sel_i & ~(wide_sel_i & hsync_off_i);
      end
    end
  end

  AST_EOL_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    eol_o |-> (dot_en_o && dot_cnt_o == (wide_act_o ? W_LAST : N_LAST))); // R9
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    eol_o |=> (dot_cnt_o == 10'd0 && !eol_o)); // R4
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dot_cnt_o <= (wide_act_o ? W_LAST : N_LAST)); // R4
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eol_o |=> ($stable(wide_act_o) && $stable(ext_act_o))); // R8
  AST_INT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_en_o && !ext_act_o) |=> !dot_en_o); // R2
  AST_EXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_en_o && ext_act_o) |-> ($past(ext_clk_i, 2) && !$past(ext_clk_i, 3))); // R7
  AST_HSYNC_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (eol_o && wide_sel_i && hsync_off_i) |=> !ext_act_o); // R6
endmodule

// File: tb/dot_tick_gen_tb.sv
module dot_tick_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_sel = 1'b0, wide_sel = 1'b0, hoff = 1'b0, ext_clk = 1'b0;
  logic dot_en, eol, wide_act, ext_act;
  logic [9:0] dot_cnt;

  int compared = 0, mismatched = 0;
  bit done = 0;
  int q_dots[$], q_cyc[$], q_wide[$], q_ext[$];

  always #5 clk = ~clk;

  dot_tick_gen u_dut (
    .clk(clk), .rst_n(rst_n), .clk_src_sel_i(src_sel), .wide_sel_i(wide_sel),
    .hsync_off_i(hoff), .ext_clk_i(ext_clk), .dot_en_o(dot_en),
    .dot_cnt_o(dot_cnt), .eol_o(eol), .wide_act_o(wide_act), .ext_act_o(ext_act)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected line: cyc = -1 when phase to the external clock is not fixed
  task automatic push_line(input bit w, input bit e, input int cyc);
    q_dots.push_back(w ? 840 : 684);
    q_wide.push_back(w);
    q_ext.push_back(e);
    q_cyc.push_back(cyc);
  endtask

  // external clock: period 6 master cycles
  initial forever begin
    repeat (3) @(negedge clk);
    ext_clk = ~ext_clk;
  end

  int n = 0, last_n = 0, dcount = 0;
  bit chk_zero = 0;
  always @(negedge clk) if (rst_n && !done) begin
    n++;
    if (chk_zero) begin
      check("R9 counter back to 0", dot_cnt, 0);
      chk_zero = 0;
    end
    if (dot_en) dcount++;
    if (eol) begin
      if (q_dots.size() == 0) check("R8 unexpected line end", 1, 0);
      else begin
        int ed, ec, ew, ee;
        ed = q_dots.pop_front(); ec = q_cyc.pop_front();
        ew = q_wide.pop_front(); ee = q_ext.pop_front();
        check("R4 dots per line", dcount, ed);
        check("R9 count at wrap", dot_cnt, ed - 1);
        check("R3/R8 wide_act", wide_act, ew);
        check("R6/R8 ext_act", ext_act, ee);
        if (ec >= 0) check("R1/R2/R5 cycles per line", n - last_n, ec);
      end
      dcount = 0;
      last_n = n;
      chk_zero = 1;
    end
  end

  task automatic run_line(input bit w, input bit e, input bit h, input int cyc);
    do @(negedge clk); while (!eol);
    wide_sel = w; src_sel = e; hoff = h;
    push_line(w, e & ~(w & h), cyc);
    repeat (10) @(negedge clk);
    wide_sel = ~w; src_sel = ~e; hoff = ~h;
  endtask

  initial begin
    push_line(0, 0, -1);
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 dot_en in reset", dot_en, 0);
    check("R10 eol in reset", eol, 0);
    check("R10 count in reset", dot_cnt, 0);
    check("R10 wide_act in reset", wide_act, 0);
    check("R10 ext_act in reset", ext_act, 0);
    wide_sel = 1; src_sel = 1; hoff = 0;
    rst_n = 1'b1;
    run_line(0, 0, 0, 3420);     // R5 R2 narrow internal
    run_line(1, 0, 0, 3360);     // R5 R2 wide internal
    run_line(1, 1, 0, -1);       // R1 first external line
    run_line(1, 1, 0, 840 * 6);  // R1 wide external
    run_line(0, 1, 0, 684 * 6);  // R1 R3 narrow external
    run_line(0, 1, 1, 684 * 6);  // R6 hsync-off ignored in narrow
    run_line(1, 1, 1, 3360);     // R6 override to internal /4
    run_line(0, 0, 0, 3420);     // R2 back to narrow internal
    run_line(1, 0, 1, 3360);     // R6 wide internal with hsync off
    do @(negedge clk); while (!eol);
    repeat (3) @(negedge clk);
    check("R8 all lines retired", q_dots.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule